// File: doc/BRIEF.md
# Supervisor Timer Pending Generator

This block produces two timer interrupt pending flags for one hart: a supervisor flag and a virtual-supervisor flag. It keeps its own copies of the supervisor compare value, the virtual-supervisor compare value, the guest time offset and the two timer-compare enable bits. The enable bits come from the machine configuration register and the hypervisor configuration register. It also keeps the most recent 64-bit time sample broadcast by the core-local timer.

Neither flag is compared continuously. Each flag is re-evaluated only when one of its own trigger events occurs. The supervisor flag reacts to a time sample, a supervisor compare write and a machine configuration write. The virtual-supervisor flag reacts to a time sample, a virtual-supervisor compare write, an offset write, a machine configuration write and a hypervisor configuration write. In every other cycle a flag holds its value.

A trigger evaluates with the values that the same clock edge stores, so a write takes effect in the result at once. All inputs are plain strobes with data. The block never stalls a strobe: a write or time sample is accepted in the cycle its strobe is high. There is no ready signal and there is no back-pressure.

Top module: `stimer_pend`

## Requirements
- R1: After reset both `s_pend` and `vs_pend` are 0. The time copy and the offset reset to 0. Both compare values reset to all ones, and both enable bits reset to 0.
- R2: On a cycle with `tick_vld` high and the machine enable set, `s_pend` becomes 1 exactly when `tick_time` >= the supervisor compare value, as an unsigned compare with equality counting as pending. The flag is valid from the next clock edge.
- R3: While the machine enable bit is 0, `s_pend` is 0. A trigger seen with the enable clear forces the flag to 0.
- R4: A write on `scmp_we` re-evaluates `s_pend` against the newly written value and the stored time sample.
- R5: A write on `menv_we` stores `menv_ena` and re-evaluates both flags with the new enable.
- R6: With both enables set, `vs_pend` is 1 exactly when (time + offset) mod 2^64 >= the virtual-supervisor compare value. If either enable is 0, `vs_pend` is 0.
- R7: `vs_pend` is re-evaluated on writes to `vscmp_we`, `delta_we` and `henv_we`, each using its new value.
- R8: In a cycle with none of its trigger events, a flag keeps its value. This holds when `tick_time` changes without `tick_vld`, and it holds for `vs_pend` on a supervisor compare write.
- R9: The offset addition wraps modulo 2^64, so a large offset can make the guest time smaller than the host time.
- R10: With a compare value still at its reset value, a flag is set only by a time of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_vld | input | 1 | Time sample strobe |
| tick_time | input | 64 | Time sample |
| scmp_we | input | 1 | Supervisor compare write strobe |
| scmp_wdata | input | 64 | Supervisor compare write value |
| vscmp_we | input | 1 | Virtual-supervisor compare write strobe |
| vscmp_wdata | input | 64 | Virtual-supervisor compare write value |
| delta_we | input | 1 | Guest time offset write strobe |
| delta_wdata | input | 64 | Guest time offset write value |
| menv_we | input | 1 | Machine configuration write strobe |
| menv_ena | input | 1 | Machine timer-compare enable bit being written |
| henv_we | input | 1 | Hypervisor configuration write strobe |
| henv_ena | input | 1 | Hypervisor timer-compare enable bit being written |
| s_pend | output | 1 | Supervisor timer pending |
| vs_pend | output | 1 | Virtual-supervisor timer pending |

## Verification
Every result is due one clock edge after its stimulus. The strobe and data are stored on that edge, and the flag that depends on them updates on the same edge. The bench drives each stimulus on the falling edge and holds it for one cycle. It then samples both flags 1 ns after the next rising edge, before it drives the next stimulus. The hold checks let extra cycles pass without a trigger and then confirm that neither flag moved.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
  localparam int TW = 64;
  typedef logic [TW-1:0] tword_t;
  localparam tword_t CMP_RST = '1;
endpackage

// File: rtl/stimer_reg.sv
module stimer_reg #(
  parameter int W = 64,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q,
  output logic [W-1:0] nx
);
  // value that the coming edge stores; lets evaluation see a write at once
  always_comb nx = we ? wd : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST;
    else        q <= nx;
  end
endmodule

// File: rtl/stimer_eval.sv
module stimer_eval #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         en,
  input  logic [W-1:0] cur_t,
  input  logic [W-1:0] ofs,
  input  logic [W-1:0] cmp,
  output logic         pend
);
  logic [W-1:0] eff_t;
  logic         hit;

  always_comb begin
    eff_t = cur_t + ofs;          // wraps modulo 2^W
    hit   = en && (eff_t >= cmp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= 1'b0;
    else if (upd) pend <= hit;
  end

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(pend)); // R8
  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !en) |=> !pend); // R3
endmodule

// File: rtl/stimer_pend.sv
module stimer_pend
  import stimer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_vld,
  input  logic [63:0] tick_time,
  input  logic        scmp_we,
  input  logic [63:0] scmp_wdata,
  input  logic        vscmp_we,
  input  logic [63:0] vscmp_wdata,
  input  logic        delta_we,
  input  logic [63:0] delta_wdata,
  input  logic        menv_we,
  input  logic        menv_ena,
  input  logic        henv_we,
  input  logic        henv_ena,
  output logic        s_pend,
  output logic        vs_pend
);
  tword_t time_q, time_nx, scmp_q, scmp_nx, vscmp_q, vscmp_nx, delta_q, delta_nx;
  logic   men_q, men_nx, hen_q, hen_nx;
  logic   ev_s, ev_v, en_s, en_v;

  stimer_reg #(.W(TW), .RST('0)) u_time (
    .clk(clk), .rst_n(rst_n), .we(tick_vld), .wd(tick_time), .q(time_q), .nx(time_nx));
  stimer_reg #(.W(TW), .RST(CMP_RST)) u_scmp (
    .clk(clk), .rst_n(rst_n), .we(scmp_we), .wd(scmp_wdata), .q(scmp_q), .nx(scmp_nx));
  stimer_reg #(.W(TW), .RST(CMP_RST)) u_vscmp (
    .clk(clk), .rst_n(rst_n), .we(vscmp_we), .wd(vscmp_wdata), .q(vscmp_q), .nx(vscmp_nx));
  stimer_reg #(.W(TW), .RST('0)) u_delta (
    .clk(clk), .rst_n(rst_n), .we(delta_we), .wd(delta_wdata), .q(delta_q), .nx(delta_nx));
  stimer_reg #(.W(1), .RST(1'b0)) u_men (
    .clk(clk), .rst_n(rst_n), .we(menv_we), .wd(menv_ena), .q(men_q), .nx(men_nx));
  stimer_reg #(.W(1), .RST(1'b0)) u_hen (
    .clk(clk), .rst_n(rst_n), .we(henv_we), .wd(henv_ena), .q(hen_q), .nx(hen_nx));

  always_comb begin
    ev_s = tick_vld | scmp_we | menv_we;
    ev_v = tick_vld | vscmp_we | delta_we | menv_we | henv_we;
    en_s = men_nx;
    en_v = men_nx & hen_nx;
  end

  stimer_eval #(.W(TW)) u_eval_s (
    .clk(clk), .rst_n(rst_n), .upd(ev_s), .en(en_s),
    .cur_t(time_nx), .ofs('0), .cmp(scmp_nx), .pend(s_pend));
  stimer_eval #(.W(TW)) u_eval_vs (
    .clk(clk), .rst_n(rst_n), .upd(ev_v), .en(en_v),
    .cur_t(time_nx), .ofs(delta_nx), .cmp(vscmp_nx), .pend(vs_pend));

  AST_S_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !men_q |-> !s_pend); // R3
  AST_VS_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(men_q && hen_q) |-> !vs_pend); // R6
  AST_S_TICK_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_vld && men_q && !menv_we && !scmp_we)
      |=> (s_pend == ($past(tick_time) >= $past(scmp_q)))); // R2
endmodule

// File: tb/sim_stimer_pend.sv
module sim_stimer_pend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_vld = 1'b0;
  logic [63:0] tick_time = '0;
  logic        scmp_we = 1'b0;
  logic [63:0] scmp_wdata = '0;
  logic        vscmp_we = 1'b0;
  logic [63:0] vscmp_wdata = '0;
  logic        delta_we = 1'b0;
  logic [63:0] delta_wdata = '0;
  logic        menv_we = 1'b0;
  logic        menv_ena = 1'b0;
  logic        henv_we = 1'b0;
  logic        henv_ena = 1'b0;
  logic        s_pend, vs_pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stimer_pend u0 (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after next rising edge, then clear strobes
  task automatic step();
    @(posedge clk); #1;
    tick_vld = 0; scmp_we = 0; vscmp_we = 0; delta_we = 0; menv_we = 0; henv_we = 0;
  endtask
  task automatic do_tick(logic [63:0] t);
    @(negedge clk); tick_vld = 1; tick_time = t; step();
  endtask
  task automatic do_scmp(logic [63:0] v);
    @(negedge clk); scmp_we = 1; scmp_wdata = v; step();
  endtask
  task automatic do_vscmp(logic [63:0] v);
    @(negedge clk); vscmp_we = 1; vscmp_wdata = v; step();
  endtask
  task automatic do_delta(logic [63:0] v);
    @(negedge clk); delta_we = 1; delta_wdata = v; step();
  endtask
  task automatic do_menv(logic b);
    @(negedge clk); menv_we = 1; menv_ena = b; step();
  endtask
  task automatic do_henv(logic b);
    @(negedge clk); henv_we = 1; henv_ena = b; step();
  endtask

  task automatic t_reset();
    chk("R1 s_pend", s_pend, 1'b0);
    chk("R1 vs_pend", vs_pend, 1'b0);
  endtask

  task automatic t_reset_cmp();
    do_menv(1);               chk("R10 enable only", s_pend, 1'b0);
    do_tick(64'hFFFF_FFFF_FFFF_FFFE); chk("R10 below all ones", s_pend, 1'b0);
    do_tick('1);              chk("R10 all ones", s_pend, 1'b1);
  endtask

  task automatic t_tick();
    do_scmp(100);             chk("R4 write below time", s_pend, 1'b1);
    do_tick(50);              chk("R2 time below", s_pend, 1'b0);
    do_tick(100);             chk("R2 time equal", s_pend, 1'b1);
    do_tick(99);              chk("R2 time drops", s_pend, 1'b0);
  endtask

  task automatic t_cmp_write();
    do_tick(200);             chk("R2 time above", s_pend, 1'b1);
    do_scmp(300);             chk("R4 write above time", s_pend, 1'b0);
    do_scmp(150);             chk("R4 write below time", s_pend, 1'b1);
  endtask

  task automatic t_menv();
    do_menv(0);               chk("R3 menv clear", s_pend, 1'b0);
    do_tick(500);             chk("R3 tick while disabled", s_pend, 1'b0);
    do_menv(1);               chk("R5 menv set re-evaluates", s_pend, 1'b1);
  endtask

  task automatic t_hold();
    @(negedge clk); tick_time = 0;
    @(posedge clk); #1; @(posedge clk); #1;
    chk("R8 time change without strobe", s_pend, 1'b1);
  endtask

  task automatic t_virt();
    // time stored = 500
    do_henv(1);               chk("R7 henv set, reset compare", vs_pend, 1'b0);
    do_vscmp(560);            chk("R7 vscmp above", vs_pend, 1'b0);
    do_delta(60);             chk("R7 delta reaches compare", vs_pend, 1'b1);
    do_vscmp(561);            chk("R7 vscmp raised", vs_pend, 1'b0);
    do_tick(501);             chk("R6 tick plus delta equal", vs_pend, 1'b1);
    do_scmp('1);              chk("R8 scmp write leaves vs_pend", vs_pend, 1'b1);
    chk("R4 scmp all ones", s_pend, 1'b0);
    do_henv(0);               chk("R7 henv clear", vs_pend, 1'b0);
    do_henv(1);               chk("R7 henv set again", vs_pend, 1'b1);
    do_menv(0);               chk("R5 menv clear vs", vs_pend, 1'b0);
    chk("R5 menv clear s", s_pend, 1'b0);
    do_menv(1);               chk("R5 menv set vs", vs_pend, 1'b1);
  endtask

  task automatic t_wrap();
    do_delta(64'hFFFF_FFFF_FFFF_FF9C); // -100
    chk("R9 wrapped sum below", vs_pend, 1'b0);
    do_tick(150);             chk("R9 sum 50 vs 561", vs_pend, 1'b0);
    do_vscmp(50);             chk("R9 sum 50 vs 50", vs_pend, 1'b1);
    do_vscmp(51);             chk("R9 sum 50 vs 51", vs_pend, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_reset_cmp();
    t_tick();
    t_cmp_write();
    t_menv();
    t_hold();
    t_virt();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule